// File: doc/BRIEF.md
# Self-Test Pattern Error Monitor

This block sits behind a link's word aligner and judges whether the received 10-bit words match the test pattern that the transmit side is sending. It knows two kinds of pattern. The first is a user word, sent either unchanged every time or alternating with its bitwise inverse. The second is a pseudo-random bit sequence of period 127 (polynomial x^7 + x^6 + 1), sent either true or inverted. The mode inputs are the same ones the pattern generator uses, so software programs both sides from one set of controls.

A run starts when the monitor enable is raised. The block then checks a fixed number of valid received words, 512 by default. At the end it holds a completion flag and a pass/fail flag, and software reads both as status bits. Lowering the enable clears both flags and re-arms the monitor. In pseudo-random mode the monitor seeds its own shift register from the first received word, so it needs no knowledge of the generator's starting state.

Top module: `selftest_mon`

## Requirements
- R1: On the clock cycle after an edge at which `mon_en` is sampled 0, both `test_done` and `test_fail` are 0. Received words that arrive while the monitor is disabled have no effect.
- R2: Counting begins at the first edge where `mon_en` is 1. Each edge where `rx_valid` is 1 before completion counts one word, and edges where `rx_valid` is 0 do not count. `test_done` rises on the edge that counts word number CHECK_LEN (512 by default).
- R3: While `mon_en` stays 1, `test_done` and `test_fail` are sticky. Words that arrive after completion cannot change `test_fail`.
- R4: `prbs_mode`, `inv_mode` and `pattern` are captured on the last edge where `mon_en` is 0. Changing them during a run has no effect on that run.
- R5: In fixed user mode (`prbs_mode`=0, `inv_mode`=0), every counted word is compared with `pattern`. Any mismatch sets `test_fail` on the edge that counts that word.
- R6: In alternating user mode (`prbs_mode`=0, `inv_mode`=1), the first counted word must equal either `pattern` or its bitwise inverse. That word fixes the phase, and each later word must be the inverse of the one expected before it. A first word that is neither value, or a later word that breaks the alternation, sets `test_fail`.
- R7: In pseudo-random mode (`prbs_mode`=1, `inv_mode`=0), bit 9 of a word is the earliest serial bit and bit 0 the latest. The serial stream obeys b[n] = b[n-6] XOR b[n-7]. The first counted word seeds the monitor with its bits 6..0. Every later word must equal the next ten bits of the sequence, and a mismatch sets `test_fail`.
- R8: In inverted pseudo-random mode (`prbs_mode`=1, `inv_mode`=1), every received bit is the complement of the sequence in R7. The monitor removes the inversion before seeding and before comparing.
- R9: In pseudo-random mode, a first word whose bits 6..0 are all zero after any inversion is removed sets `test_fail`.
- R10: When the word that completes the run is wrong, `test_done` and `test_fail` both rise on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mon_en | input | 1 | Monitor enable; 0 clears the flags, 1 runs the check |
| prbs_mode | input | 1 | 1 selects the pseudo-random pattern, 0 the user pattern |
| inv_mode | input | 1 | Inverts the pseudo-random pattern, or makes the user pattern alternate with its inverse |
| pattern | input | 10 | User pattern word |
| rx_valid | input | 1 | A received word is present this cycle |
| rx_word | input | 10 | Aligned received word |
| test_done | output | 1 | Sticky: the check length has been reached |
| test_fail | output | 1 | Sticky: at least one counted word mismatched |

## Verification
The bench goes after the edges of a run.

- It sends a bad word as the very last counted word. A monitor that judges the final word one cycle late would report a pass.
- It sends corrupt words after completion. A monitor whose fail flag is not frozen would turn fail.
- It changes the mode and pattern inputs in the middle of a run. A monitor that reads them live would fail a clean run.
- It drives valid-low gaps inside a pseudo-random run. A monitor that counts them would complete too early.
- In alternating mode it starts on the inverse word, and in one run it sends a word of the wrong phase. Either one separates correct phase locking from a fixed expectation.
- It sends an all-zero seed, which a monitor without that check would accept as a stuck-at-zero link that passes.

// File: rtl/stpmon_pkg.sv
`timescale 1ns/1ps
package stpmon_pkg;

    // Received word width and shift register length of the pseudo-random source
    localparam int WORD_W = 10;
    localparam int LFSR_W = 7;

    typedef enum logic {
        SRC_USER = 1'b0,
        SRC_PRBS = 1'b1
    } src_e;

    // Configuration frozen for the length of one run
    typedef struct packed {
        src_e              src;
        logic              inv;
        logic [WORD_W-1:0] pat;
    } cfg_t;

endpackage

// File: rtl/stpmon_prbs_step.sv
`timescale 1ns/1ps
// Advances the local shift register by one word's worth of serial bits.
// state[0] holds the newest bit and state[LFSR_W-1] the oldest.
module stpmon_prbs_step #(
    parameter int WORD_W = stpmon_pkg::WORD_W,
    parameter int LFSR_W = stpmon_pkg::LFSR_W
) (
    input  logic [LFSR_W-1:0] state_i,
    output logic [WORD_W-1:0] word_o,
    output logic [LFSR_W-1:0] state_o
);

    always_comb begin
        logic [LFSR_W-1:0] st;
        logic              fb;
        st     = state_i;
        word_o = '0;
        for (int i = 0; i < WORD_W; i++) begin
            fb                 = st[LFSR_W-1] ^ st[LFSR_W-2];
            word_o[WORD_W-1-i] = fb;
            st                 = {st[LFSR_W-2:0], fb};
        end
        state_o = st;
    end

endmodule

// File: rtl/stpmon_expect.sv
`timescale 1ns/1ps
// Selects the word the monitor expects next.
module stpmon_expect
    import stpmon_pkg::*;
#(
    parameter int WORD_W = stpmon_pkg::WORD_W
) (
    input  src_e              src_i,
    input  logic              alt_i,
    input  logic              phase_i,
    input  logic [WORD_W-1:0] pat_i,
    input  logic [WORD_W-1:0] prbs_word_i,
    output logic [WORD_W-1:0] exp_o
);

    logic [WORD_W-1:0] user_word;

    for (genvar b = 0; b < WORD_W; b++) begin : g_user_bit
        assign user_word[b] = pat_i[b] ^ (alt_i & phase_i);
    end

    always_comb begin
        if (src_i == SRC_PRBS) begin
            exp_o = prbs_word_i;
        end else begin
            exp_o = user_word;
        end
    end

endmodule

// File: rtl/stpmon_len_ctr.sv
`timescale 1ns/1ps
// Counts checked words and raises a sticky completion flag.
module stpmon_len_ctr #(
    parameter int CHECK_LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    output logic done_o
);

    localparam int CNT_W = $clog2(CHECK_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHECK_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctr_t;

    ctr_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr_i) begin
            c_d = '0;
        end else if (step_i && !c_q.done) begin
            c_d.cnt = c_q.cnt + 1'b1;
            if (c_q.cnt == LAST) begin
                c_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign done_o = c_q.done;

endmodule

// File: rtl/selftest_mon.sv
`timescale 1ns/1ps
module selftest_mon
    import stpmon_pkg::*;
#(
    parameter int CHECK_LEN = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_en,
    input  logic              prbs_mode,
    input  logic              inv_mode,
    input  logic [WORD_W-1:0] pattern,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    output logic              test_done,
    output logic              test_fail
);

    typedef struct packed {
        cfg_t              cfg;
        logic              seeded;
        logic              phase;
        logic [LFSR_W-1:0] lfsr;
        logic              fail;
    } mon_t;

    mon_t s_d, s_q;

    logic              done;
    logic              step;
    logic              clr;
    logic [WORD_W-1:0] prbs_word;
    logic [LFSR_W-1:0] prbs_next;
    logic [WORD_W-1:0] exp_word;
    logic [WORD_W-1:0] rx_fix;

    stpmon_prbs_step #(
        .WORD_W (WORD_W),
        .LFSR_W (LFSR_W)
    ) u_prbs (
        .state_i (s_q.lfsr),
        .word_o  (prbs_word),
        .state_o (prbs_next)
    );

    stpmon_expect #(
        .WORD_W (WORD_W)
    ) u_expect (
        .src_i       (s_q.cfg.src),
        .alt_i       (s_q.cfg.inv),
        .phase_i     (s_q.phase),
        .pat_i       (s_q.cfg.pat),
        .prbs_word_i (prbs_word),
        .exp_o       (exp_word)
    );

    stpmon_len_ctr #(
        .CHECK_LEN (CHECK_LEN)
    ) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .step_i (step),
        .done_o (done)
    );

    always_comb begin
        s_d    = s_q;
        clr    = !mon_en;
        step   = 1'b0;
        // Undo inversion only for the inverted pseudo-random mode
        rx_fix = rx_word ^ {WORD_W{(s_q.cfg.src == SRC_PRBS) && s_q.cfg.inv}};

        if (!mon_en) begin
            s_d         = '0;
            s_d.cfg.src = prbs_mode ? SRC_PRBS : SRC_USER;
            s_d.cfg.inv = inv_mode;
            s_d.cfg.pat = pattern;
        end else if (rx_valid && !done) begin
            step       = 1'b1;
            s_d.seeded = 1'b1;
            if (!s_q.seeded) begin
                if (s_q.cfg.src == SRC_PRBS) begin
                    s_d.lfsr = rx_fix[LFSR_W-1:0];
                    if (rx_fix[LFSR_W-1:0] == '0) begin
                        s_d.fail = 1'b1;
                    end
                end else if (s_q.cfg.inv) begin
                    if (rx_word == s_q.cfg.pat) begin
                        s_d.phase = 1'b1;
                    end else if (rx_word == ~s_q.cfg.pat) begin
                        s_d.phase = 1'b0;
                    end else begin
                        s_d.phase = 1'b1;
                        s_d.fail  = 1'b1;
                    end
                end else if (rx_word != s_q.cfg.pat) begin
                    s_d.fail = 1'b1;
                end
            end else begin
                if (rx_fix != exp_word) begin
                    s_d.fail = 1'b1;
                end
                if (s_q.cfg.src == SRC_PRBS) begin
                    s_d.lfsr = prbs_next;
                end else if (s_q.cfg.inv) begin
                    s_d.phase = !s_q.phase;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign test_done = done;
    assign test_fail = s_q.fail;

endmodule

// File: rtl/selftest_mon_checker.sv
`timescale 1ns/1ps
module selftest_mon_checker (
    input logic clk,
    input logic rst_n,
    input logic mon_en,
    input logic rx_valid,
    input logic test_done,
    input logic test_fail
);

    assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> (!test_done && !test_fail));

    assert_done_needs_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_done && !rx_valid) |=> !test_done);

    assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && test_done) |=> test_done);

    assert_fail_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && test_fail) |=> test_fail);

    assert_fail_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && test_done) |=> $stable(test_fail));

    assert_fail_needs_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_fail && !rx_valid) |=> !test_fail);

endmodule

bind selftest_mon selftest_mon_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_en    (mon_en),
    .rx_valid  (rx_valid),
    .test_done (test_done),
    .test_fail (test_fail)
);

// File: tb/selftest_mon_bench.sv
`timescale 1ns/1ps
module selftest_mon_bench;

    localparam int LEN = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mon_en = 1'b0;
    logic       prbs_mode = 1'b0;
    logic       inv_mode = 1'b0;
    logic [9:0] pattern = '0;
    logic       rx_valid = 1'b0;
    logic [9:0] rx_word = '0;
    logic       test_done;
    logic       test_fail;

    always #2 clk = ~clk;

    selftest_mon #(.CHECK_LEN(LEN)) u_selftest_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_en    (mon_en),
        .prbs_mode (prbs_mode),
        .inv_mode  (inv_mode),
        .pattern   (pattern),
        .rx_valid  (rx_valid),
        .rx_word   (rx_word),
        .test_done (test_done),
        .test_fail (test_fail)
    );

    typedef struct {
        int    cyc;
        logic  d;
        logic  f;
        string tag;
    } item_t;

    item_t sb_q[$];
    int    cyc = 0;
    int    n_checks = 0;
    int    n_bad = 0;
    bit    finished = 0;

    // Reference model state
    int    m_cnt = 0;
    bit    m_done = 0;
    bit    m_fail = 0;

    // Serial reference sequence
    bit    pq[$];

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares results one clock after the word was driven
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].cyc < cyc) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (test_done !== it.d || test_fail !== it.f) begin
                n_bad++;
                $display("FAIL %s: done=%0b fail=%0b expected done=%0b fail=%0b",
                         it.tag, test_done, test_fail, it.d, it.f);
            end
        end
    end

    task automatic step(input bit en, input bit valid, input logic [9:0] word,
                        input bit bad, input string tag);
        item_t it;
        @(negedge clk);
        mon_en   = en;
        rx_valid = valid;
        rx_word  = word;
        if (!en) begin
            m_cnt = 0; m_done = 0; m_fail = 0;
        end else if (valid && !m_done) begin
            if (bad) m_fail = 1;
            m_cnt++;
            if (m_cnt == LEN) m_done = 1;
        end
        it.cyc = cyc; it.d = m_done; it.f = m_fail; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic set_cfg(input bit p, input bit i, input logic [9:0] pat);
        @(negedge clk);
        prbs_mode = p; inv_mode = i; pattern = pat;
        step(0, 0, 10'h0, 0, "R1 idle");
    endtask

    task automatic gen_seed(input logic [6:0] s);
        pq.delete();
        for (int k = 6; k >= 0; k--) pq.push_back(s[k]);
    endtask

    function automatic logic [9:0] gen_word();
        logic [9:0] w;
        for (int k = 9; k >= 0; k--) begin
            int n;
            bit b;
            n = pq.size();
            b = pq[n-6] ^ pq[n-7];
            pq.push_back(b);
            w[k] = b;
        end
        while (pq.size() > 16) void'(pq.pop_front());
        return w;
    endfunction

    // User pattern run; bad_at < 0 means no error. Words after LEN are corrupt.
    task automatic run_user(input logic [9:0] pat, input bit alt, input bit first_inv,
                            input int n, input int bad_at, input string tag);
        set_cfg(0, alt, pat);
        for (int k = 0; k < n; k++) begin
            logic [9:0] w;
            bit bad;
            w   = (alt && (first_inv ^ k[0])) ? ~pat : pat;
            bad = (k == bad_at) || (k >= LEN);
            if (bad) w = w ^ ((alt && k > 0) ? 10'h3FF : 10'h004);
            step(1, 1, w, bad, tag);
        end
        step(0, 1, 10'h155, 0, "R1 disable");
        step(0, 0, 10'h0, 0, "R1 disable");
    endtask

    task automatic run_prbs(input bit inv, input logic [6:0] seed, input int n,
                            input int bad_at, input bit gaps, input bit chg,
                            input string tag);
        set_cfg(1, inv, 10'h0F0);
        gen_seed(seed);
        for (int k = 0; k < n; k++) begin
            logic [9:0] w;
            bit bad;
            w = gen_word();
            if (inv) w = ~w;
            bad = (k == bad_at) || (k >= LEN);
            if (bad) w = w ^ 10'h100;
            if (gaps && (k % 5 == 2)) step(1, 0, ~w, 0, "R2 gap");
            if (chg && k == 200) begin
                prbs_mode = 0; inv_mode = ~inv; pattern = 10'h2AA;
            end
            step(1, 1, w, bad, tag);
        end
        step(0, 0, 10'h0, 0, "R1 disable");
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 10'h0, 0, "R1 reset");
        // Words while disabled are ignored
        for (int k = 0; k < 6; k++) step(0, 1, 10'h3FF ^ 10'(k), 0, "R1 disabled words");

        run_user(10'h2B5, 0, 0, LEN + 4, -1,  "R5 fixed pass / R3 after done");
        run_user(10'h2B5, 0, 0, LEN + 2, 100, "R5 fixed error");
        run_user(10'h0C7, 1, 1, LEN + 3, -1,  "R6 alternate inverse-first pass");
        run_user(10'h0C7, 1, 0, LEN,     0,   "R6 bad first word");
        run_user(10'h31A, 1, 0, LEN,     77,  "R6 phase break");
        run_prbs(0, 7'h53, LEN + 3, -1, 1, 0, "R7 pass with gaps / R2");
        run_prbs(1, 7'h1F, LEN,     -1, 0, 0, "R8 inverted pass");
        run_prbs(1, 7'h1F, LEN,     300, 0, 0, "R8 inverted error");
        run_prbs(0, 7'h41, LEN + 2, LEN - 1, 0, 0, "R10 last word bad / R7");
        run_prbs(0, 7'h66, LEN,     -1, 0, 1, "R4 mode change mid-run");

        // R9: zero seed word
        set_cfg(1, 0, 10'h0);
        step(1, 1, 10'h380, 1, "R9 zero seed");
        for (int k = 0; k < 4; k++) step(1, 1, 10'h000, 0, "R9 zero seed");
        step(0, 0, 10'h0, 0, "R1 disable");
        // R9 with inversion: all-ones low bits map to zero seed
        set_cfg(1, 1, 10'h0);
        step(1, 1, 10'h07F, 1, "R9 inverted zero seed");
        step(0, 0, 10'h0, 0, "R1 disable");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
        $finish;
    end

endmodule